// File: doc/BRIEF.md
# Gated Control Register Bank

This block holds the configuration and run-status registers of a network controller. A host reaches six register addresses through a plain address, write-data, write-strobe and read-strobe port, with a registered read-data return. Every configuration write is accepted only while the controller is halted (stop input high) or suspended (suspend input high). At any other time a write is dropped. Each register has its own rule for which reset clears it.

From the stored mode bits and a few live inputs, the block derives four things. It produces transmit-on and receive-on status, an encoded loopback mode, and a full-duplex indication that is forced while loopback is enabled. It also gives a per-frame decision on whether the frame-check sequence (FCS) is appended. The decision follows a fixed priority: the auto-pad flag is checked first, then the per-frame request, then the stored disable bit.

The run status comes from a two-state machine. `RUN_HALT` moves to `RUN_ACTIVE` on the START transition, taken when start is high, stop is low and no reset is present. `RUN_ACTIVE` moves back to `RUN_HALT` on the STOP transition, taken when stop is high or either reset is present.

Top module: `ctrl_reg_bank`

## Requirements
- R1: Writes land only when stop or suspend is high. The mode register sits at address 0 and holds six bits: bit0 no_rx, bit1 no_tx, bit2 loop_en, bit3 no_fcs, bit4 intl, bit5 mii_lp. Bits 31:6 read as zero. A write made while both stop and suspend are low changes no register.
- R2: Hard reset clears the mode register and both initialization-address registers. It leaves the receive-buffer register unchanged. A write in a hard-reset cycle is dropped.
- R3: Soft reset clears only loop_en. It leaves the other mode bits, the address registers and the receive-buffer register unchanged, and a write in that cycle is dropped. The stop input by itself never changes a stored register.
- R4: `lpbk_mode` decodes the triple (loop_en, intl, mii_lp) as follows: 0,0,0 gives 00 (normal), 0,0,1 gives 01 (internal loop), 1,0,0 gives 10 (external loop), and any other triple gives 11.
- R5: `full_duplex` is 1 whenever loop_en is 1. Otherwise it equals `fdx_cfg`.
- R6: START moves the run state to active at the next edge, and STOP (stop or either reset) returns it to halted at the next edge, with stop taking priority over start. `tx_on` is high exactly when the state is active and no_tx is 0.
- R7: `rx_on` is high exactly when the state is active and no_rx is 0.
- R8: `fcs_append` is 1 if `auto_pad` is 1, otherwise 1 if `frame_add_fcs` is 1, otherwise the inverse of no_fcs.
- R9: Addresses 1 and 3 share one 16-bit initialization-address-low register, and addresses 2 and 4 share one high register. A write through either address of a pair is read back identically through both.
- R10: The receive-buffer register is at address 5. For addresses 1 to 5, write bits 31:16 are discarded and read bits 31:16 are zero.
- R11: Addresses 6 and 7 are unmapped. Reading them returns zero, and writing them changes nothing.
- R12: `rdata` shows the value of the addressed register, as it stood before that edge, in the cycle after a read strobe. It is zero in the cycle after a cycle with no read strobe, and zero after hard reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hard_rst | input | 1 | Synchronous hard reset, active high |
| soft_rst | input | 1 | Synchronous soft reset, active high |
| stop_i | input | 1 | Controller halted; opens configuration writes |
| spnd_i | input | 1 | Controller suspended; opens configuration writes |
| strt_i | input | 1 | Start request |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| frame_add_fcs | input | 1 | Per-frame FCS request |
| auto_pad | input | 1 | Auto-pad transmit flag |
| fdx_cfg | input | 1 | External full-duplex setting |
| tx_on | output | 1 | Transmit running |
| rx_on | output | 1 | Receive running |
| lpbk_mode | output | 2 | Encoded loopback mode |
| full_duplex | output | 1 | Effective duplex |
| fcs_append | output | 1 | Append FCS to current frame |

## Verification
The assertions rely on three conditions. Hard reset must be held from time zero through at least one edge. Every input must be steady around each rising edge. The receive-buffer register, which no reset initialises, must not be read before it has been written. The bench drives all inputs on the falling edge and starts with several hard-reset cycles. During random traffic it redirects any read of address 5 to address 0 until its reference model has recorded an accepted write there. Resets, stop, suspend and start are drawn with mixed weights so that gated and ungated writes, soft resets inside run periods, and start together with stop all occur.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic {
        RUN_HALT   = 1'b0,
        RUN_ACTIVE = 1'b1
    } run_state_t;

    typedef enum logic [1:0] {
        LB_NORMAL   = 2'b00,
        LB_INTERNAL = 2'b01,
        LB_EXTERNAL = 2'b10,
        LB_OTHER    = 2'b11
    } lb_mode_t;

    typedef struct packed {
        logic mii_lp;
        logic intl;
        logic no_fcs;
        logic loop_en;
        logic no_tx;
        logic no_rx;
    } mode_t;

    localparam int unsigned MODE_W    = $bits(mode_t);
    localparam int unsigned ADR_MODE  = 0;
    localparam int unsigned ADR_IBLO  = 1;
    localparam int unsigned ADR_IBHI  = 2;
    localparam int unsigned ADR_IBLO2 = 3;
    localparam int unsigned ADR_IBHI2 = 4;
    localparam int unsigned ADR_RXBUF = 5;

endpackage

// File: rtl/crb_mode_reg.sv
module crb_mode_reg
    import crb_pkg::*;
(
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic              cfg_open,
    input  logic              wr_sel,
    input  logic [MODE_W-1:0] wdata,
    output mode_t             mode_q
);

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            mode_q <= '0;
        end else if (soft_rst) begin
            mode_q.loop_en <= 1'b0;
        end else if (wr_sel && cfg_open) begin
            mode_q <= mode_t'(wdata);
        end
    end

    // R1: closed window or no write leaves the mode register as it was
    a_r1_closed_hold: assert property (@(posedge clk) disable iff (hard_rst)
        (!soft_rst && !(wr_sel && cfg_open)) |=> $stable(mode_q));

    // R2: hard reset clears every mode bit
    a_r2_hard_clear: assert property (@(posedge clk)
        hard_rst |=> (mode_q == '0));

    // R3: soft reset clears loop enable only
    a_r3_soft_loop: assert property (@(posedge clk) disable iff (hard_rst)
        soft_rst |=> (!mode_q.loop_en &&
                      $stable({mode_q.mii_lp, mode_q.intl, mode_q.no_fcs,
                               mode_q.no_tx, mode_q.no_rx})));

endmodule

// File: rtl/crb_addr_regs.sv
module crb_addr_regs #(
    parameter int unsigned FIELD_W = 16,
    parameter int unsigned N_ALIAS = 2
) (
    input  logic               clk,
    input  logic               hard_rst,
    input  logic               soft_rst,
    input  logic               cfg_open,
    input  logic [N_ALIAS-1:0] wr_iba,
    input  logic               wr_rx,
    input  logic [FIELD_W-1:0] wdata,
    output logic [FIELD_W-1:0] iba_q [N_ALIAS],
    output logic [FIELD_W-1:0] rxbuf_q
);

    logic wr_ok;
    assign wr_ok = cfg_open && !hard_rst && !soft_rst;

    for (genvar gi = 0; gi < N_ALIAS; gi++) begin : g_iba
        always_ff @(posedge clk) begin
            if (hard_rst) begin
                iba_q[gi] <= '0;
            end else if (wr_ok && wr_iba[gi]) begin
                iba_q[gi] <= wdata;
            end
        end

        // R2: hard reset clears each initialization-address register
        a_r2_iba_clear: assert property (@(posedge clk)
            hard_rst |=> (iba_q[gi] == '0));

        // R3: soft reset leaves the initialization-address register alone
        a_r3_iba_soft: assert property (@(posedge clk) disable iff (hard_rst)
            soft_rst |=> $stable(iba_q[gi]));

        // R1: no accepted write, no change
        a_r1_iba_closed: assert property (@(posedge clk) disable iff (hard_rst)
            (!cfg_open || !wr_iba[gi]) |=> $stable(iba_q[gi]));
    end

    // receive-buffer address: immune to every reset
    always_ff @(posedge clk) begin
        if (wr_ok && wr_rx) begin
            rxbuf_q <= wdata;
        end
    end

endmodule

// File: rtl/crb_run_fsm.sv
module crb_run_fsm
    import crb_pkg::*;
(
    input  logic clk,
    input  logic hard_rst,
    input  logic soft_rst,
    input  logic stop_i,
    input  logic strt_i,
    input  logic no_tx,
    input  logic no_rx,
    output logic tx_on,
    output logic rx_on
);

    run_state_t state_q;
    run_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALT: begin
                if (!stop_i && strt_i) state_d = RUN_ACTIVE;
            end
            RUN_ACTIVE: begin
                if (stop_i) state_d = RUN_HALT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (hard_rst || soft_rst) begin
            state_q <= RUN_HALT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        tx_on = 1'b0;
        rx_on = 1'b0;
        unique case (state_q)
            RUN_HALT: begin
                tx_on = 1'b0;
                rx_on = 1'b0;
            end
            RUN_ACTIVE: begin
                tx_on = !no_tx;
                rx_on = !no_rx;
            end
        endcase
    end

    // R6: start without stop or reset enters the active state
    a_r6_start: assert property (@(posedge clk) disable iff (hard_rst)
        (strt_i && !stop_i && !soft_rst) |=> (state_q == RUN_ACTIVE));

    // R6: stop or soft reset halts at the next edge
    a_r6_stop: assert property (@(posedge clk) disable iff (hard_rst)
        (stop_i || soft_rst) |=> (!tx_on && !rx_on));

    // R7: disabled receiver never reports running
    a_r7_rx_off: assert property (@(posedge clk) disable iff (hard_rst)
        no_rx |-> !rx_on);

endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import crb_pkg::*;
#(
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned ADDR_W  = 3,
    parameter int unsigned FIELD_W = 16
) (
    input  logic              clk,
    input  logic              hard_rst,
    input  logic              soft_rst,
    input  logic              stop_i,
    input  logic              spnd_i,
    input  logic              strt_i,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr_en,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rdata,
    input  logic              frame_add_fcs,
    input  logic              auto_pad,
    input  logic              fdx_cfg,
    output logic              tx_on,
    output logic              rx_on,
    output logic [1:0]        lpbk_mode,
    output logic              full_duplex,
    output logic              fcs_append
);

    localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(ADR_MODE);
    localparam logic [ADDR_W-1:0] A_IBLO  = ADDR_W'(ADR_IBLO);
    localparam logic [ADDR_W-1:0] A_IBHI  = ADDR_W'(ADR_IBHI);
    localparam logic [ADDR_W-1:0] A_IBLO2 = ADDR_W'(ADR_IBLO2);
    localparam logic [ADDR_W-1:0] A_IBHI2 = ADDR_W'(ADR_IBHI2);
    localparam logic [ADDR_W-1:0] A_RXBUF = ADDR_W'(ADR_RXBUF);
    localparam int unsigned       N_ALIAS = 2;

    logic               cfg_open;
    mode_t              mode_q;
    logic [FIELD_W-1:0] iba_q [N_ALIAS];
    logic [FIELD_W-1:0] rxbuf_q;
    logic [N_ALIAS-1:0] wr_iba;
    logic               wr_mode;
    logic               wr_rx;
    logic [DATA_W-1:0]  rd_val;
    logic               unused_hi;

    assign cfg_open  = stop_i || spnd_i;
    assign unused_hi = ^wdata[DATA_W-1:FIELD_W];

    // host write decode; aliases fold onto the same storage
    always_comb begin
        wr_mode = 1'b0;
        wr_iba  = '0;
        wr_rx   = 1'b0;
        if (wr_en) begin
            unique case (addr)
                A_MODE:           wr_mode   = 1'b1;
                A_IBLO, A_IBLO2:  wr_iba[0] = 1'b1;
                A_IBHI, A_IBHI2:  wr_iba[1] = 1'b1;
                A_RXBUF:          wr_rx     = 1'b1;
                default:          ;
            endcase
        end
    end

    crb_mode_reg u_mode (
        .clk      (clk),
        .hard_rst (hard_rst),
        .soft_rst (soft_rst),
        .cfg_open (cfg_open),
        .wr_sel   (wr_mode),
        .wdata    (wdata[MODE_W-1:0]),
        .mode_q   (mode_q)
    );

    crb_addr_regs #(
        .FIELD_W (FIELD_W),
        .N_ALIAS (N_ALIAS)
    ) u_addr (
        .clk      (clk),
        .hard_rst (hard_rst),
        .soft_rst (soft_rst),
        .cfg_open (cfg_open),
        .wr_iba   (wr_iba),
        .wr_rx    (wr_rx),
        .wdata    (wdata[FIELD_W-1:0]),
        .iba_q    (iba_q),
        .rxbuf_q  (rxbuf_q)
    );

    crb_run_fsm u_run (
        .clk      (clk),
        .hard_rst (hard_rst),
        .soft_rst (soft_rst),
        .stop_i   (stop_i),
        .strt_i   (strt_i),
        .no_tx    (mode_q.no_tx),
        .no_rx    (mode_q.no_rx),
        .tx_on    (tx_on),
        .rx_on    (rx_on)
    );

    // read mux
    always_comb begin
        rd_val = '0;
        unique case (addr)
            A_MODE:          rd_val = DATA_W'(mode_q);
            A_IBLO, A_IBLO2: rd_val = DATA_W'(iba_q[0]);
            A_IBHI, A_IBHI2: rd_val = DATA_W'(iba_q[1]);
            A_RXBUF:         rd_val = DATA_W'(rxbuf_q);
            default:         rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (hard_rst) begin
            rdata <= '0;
        end else begin
            rdata <= rd_en ? rd_val : '0;
        end
    end

    // loopback decode from (loop_en, intl, mii_lp)
    always_comb begin
        unique case ({mode_q.loop_en, mode_q.intl, mode_q.mii_lp})
            3'b000:  lpbk_mode = LB_NORMAL;
            3'b001:  lpbk_mode = LB_INTERNAL;
            3'b100:  lpbk_mode = LB_EXTERNAL;
            default: lpbk_mode = LB_OTHER;
        endcase
    end

    assign full_duplex = mode_q.loop_en ? 1'b1 : fdx_cfg;

    // fixed priority: auto-pad, then per-frame request, then stored disable
    always_comb begin
        if (auto_pad) begin
            fcs_append = 1'b1;
        end else if (frame_add_fcs) begin
            fcs_append = 1'b1;
        end else begin
            fcs_append = !mode_q.no_fcs;
        end
    end

    // R4: internal loop only reported with loop enable clear
    a_r4_internal: assert property (@(posedge clk) disable iff (hard_rst)
        (lpbk_mode == LB_INTERNAL) |-> (!mode_q.loop_en && mode_q.mii_lp));

    // R5: loopback forces full duplex
    a_r5_fdx: assert property (@(posedge clk) disable iff (hard_rst)
        mode_q.loop_en |-> full_duplex);

    // R8: either override flag forces the append
    a_r8_override: assert property (@(posedge clk) disable iff (hard_rst)
        (auto_pad || frame_add_fcs) |-> fcs_append);

    // R10: upper half of mapped address registers reads zero
    a_r10_upper_zero: assert property (@(posedge clk) disable iff (hard_rst)
        (rd_en && addr >= A_IBLO && addr <= A_RXBUF) |=> (rdata[DATA_W-1:FIELD_W] == '0));

    // R11: unmapped reads return zero
    a_r11_unmapped: assert property (@(posedge clk) disable iff (hard_rst)
        (rd_en && addr > A_RXBUF) |=> (rdata == '0));

    // R12: no strobe, zero data
    a_r12_idle_zero: assert property (@(posedge clk) disable iff (hard_rst)
        !rd_en |=> (rdata == '0));

endmodule

// File: tb/ctrl_reg_bank_test.sv
`timescale 1ns/1ps
module ctrl_reg_bank_test;

    logic        clk = 1'b0;
    logic        hard_rst, soft_rst, stop_i, spnd_i, strt_i;
    logic [2:0]  addr;
    logic [31:0] wdata;
    logic        wr_en, rd_en;
    logic [31:0] rdata;
    logic        frame_add_fcs, auto_pad, fdx_cfg;
    logic        tx_on, rx_on, full_duplex, fcs_append;
    logic [1:0]  lpbk_mode;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ctrl_reg_bank uut (
        .clk(clk), .hard_rst(hard_rst), .soft_rst(soft_rst),
        .stop_i(stop_i), .spnd_i(spnd_i), .strt_i(strt_i),
        .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
        .rdata(rdata), .frame_add_fcs(frame_add_fcs), .auto_pad(auto_pad),
        .fdx_cfg(fdx_cfg), .tx_on(tx_on), .rx_on(rx_on),
        .lpbk_mode(lpbk_mode), .full_duplex(full_duplex), .fcs_append(fcs_append)
    );

    // behavioural reference state
    logic [5:0]  m_mode;
    logic [15:0] m_lo, m_hi, m_rx;
    bit          m_run;
    logic [31:0] m_rd;
    bit          rx_valid = 0;

    function automatic logic [31:0] ref_read(input logic [2:0] a);
        case (a)
            3'd0:       return {26'd0, m_mode};
            3'd1, 3'd3: return {16'd0, m_lo};
            3'd2, 3'd4: return {16'd0, m_hi};
            3'd5:       return {16'd0, m_rx};
            default:    return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (hard_rst) begin
            m_mode = '0; m_lo = '0; m_hi = '0; m_run = 0; m_rd = '0;
        end else begin
            m_rd = rd_en ? ref_read(addr) : 32'd0;
            if (soft_rst) begin
                m_mode[2] = 1'b0;
                m_run = 0;
            end else begin
                if (wr_en && (stop_i || spnd_i)) begin
                    case (addr)
                        3'd0:       m_mode = wdata[5:0];
                        3'd1, 3'd3: m_lo = wdata[15:0];
                        3'd2, 3'd4: m_hi = wdata[15:0];
                        3'd5:       begin m_rx = wdata[15:0]; rx_valid = 1; end
                        default:    ;
                    endcase
                end
                if (stop_i) m_run = 0;
                else if (strt_i) m_run = 1;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // compare with current inputs, then let one edge pass
    task automatic tick();
        logic [1:0] lb;
        #1;
        case ({m_mode[2], m_mode[4], m_mode[5]})
            3'b000:  lb = 2'b00;
            3'b001:  lb = 2'b01;
            3'b100:  lb = 2'b10;
            default: lb = 2'b11;
        endcase
        chk("R6 tx_on", 32'(tx_on), 32'(m_run && !m_mode[1]));
        chk("R7 rx_on", 32'(rx_on), 32'(m_run && !m_mode[0]));
        chk("R4 lpbk_mode", 32'(lpbk_mode), 32'(lb));
        chk("R5 full_duplex", 32'(full_duplex), 32'(m_mode[2] ? 1'b1 : fdx_cfg));
        chk("R8 fcs_append", 32'(fcs_append),
            32'(auto_pad ? 1'b1 : (frame_add_fcs ? 1'b1 : !m_mode[3])));
        chk("R1 R2 R3 R9 R10 R11 R12 rdata", rdata, m_rd);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 0; rd_en = 0; strt_i = 0; soft_rst = 0; hard_rst = 0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        idle(); addr = a; wdata = d; wr_en = 1; tick(); idle();
    endtask

    task automatic rd(input logic [2:0] a);
        idle(); addr = a; rd_en = 1; tick(); idle(); tick();
    endtask

    initial begin
        hard_rst = 1; soft_rst = 0; stop_i = 1; spnd_i = 0; strt_i = 0;
        addr = 0; wdata = 0; wr_en = 0; rd_en = 0;
        frame_add_fcs = 0; auto_pad = 0; fdx_cfg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        idle();
        tick();                               // R2 reset state
        rd(3'd0);
        // R4 each loopback encoding
        wr(3'd0, 32'h0000_0020); rd(3'd0);    // internal
        wr(3'd0, 32'h0000_0004); rd(3'd0);    // external, R5 forced duplex
        wr(3'd0, 32'h0000_0014); rd(3'd0);    // other
        wr(3'd0, 32'hFFFF_FFC8); rd(3'd0);    // no_fcs set, upper ignored
        // R8 priority cases
        frame_add_fcs = 1; tick(); auto_pad = 1; tick(); frame_add_fcs = 0; tick();
        auto_pad = 0; tick();
        // R9 R10 aliases and rx buffer
        wr(3'd1, 32'hABCD_1234); rd(3'd3); rd(3'd1);
        wr(3'd4, 32'h5555_BEEF); rd(3'd2);
        wr(3'd5, 32'hFFFF_0F0F); rd(3'd5);
        wr(3'd7, 32'h1234_5678); rd(3'd7); rd(3'd6);   // R11
        // R6 R7 start with stop low, then ungated write ignored (R1)
        wr(3'd0, 32'h0000_0002);
        stop_i = 0; strt_i = 1; tick(); idle(); tick();
        wr(3'd0, 32'h0000_0000); rd(3'd0);
        spnd_i = 1; wr(3'd0, 32'h0000_0001); rd(3'd0); spnd_i = 0; tick();
        // R3 soft reset inside run
        soft_rst = 1; tick(); idle(); rd(3'd5); rd(3'd1);
        hard_rst = 1; tick(); idle(); rd(3'd5);          // R2 rx kept
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            hard_rst = ($urandom_range(0, 199) == 0);
            soft_rst = ($urandom_range(0, 99) == 0);
            stop_i   = ($urandom_range(0, 9) < 3);
            spnd_i   = ($urandom_range(0, 9) < 2);
            strt_i   = ($urandom_range(0, 9) < 3);
            wr_en    = ($urandom_range(0, 9) < 4);
            rd_en    = ($urandom_range(0, 9) < 4);
            addr     = 3'($urandom_range(0, 7));
            wdata    = $urandom();
            if (rd_en && addr == 3'd5 && !rx_valid) addr = 3'd0;
            frame_add_fcs = $urandom_range(0, 1) == 1;
            auto_pad      = $urandom_range(0, 3) == 0;
            fdx_cfg       = $urandom_range(0, 1) == 1;
            tick();
        end
        idle(); tick();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule